// File: doc/BRIEF.md
# Set-Associative Victim Way Selector

This block chooses which way of a set to evict when an N-way set-associative cache misses. It keeps per-set replacement state in registers for three policies at once: an exact least-recently-used ordering, a first-in-first-out insertion pointer, and a free-running pseudo-random source. The `mode_sel` control pin picks which policy answers a query. Because every policy's state is updated on every access, whatever the mode, switching modes takes effect on the next query with no warm-up.

The cache controller reports each access on the notification stream. An access gives a set, a way, and a flag that marks a fill rather than a hit. Separately, the controller asks for a victim by presenting a set on the query stream. The answer is combinational and comes in the same cycle. Both streams carry a valid qualifier only. The block takes one access and answers one query in every cycle and never exerts back-pressure, so no ready signal exists. A source may present a new item on every cycle.

Top module: `repl_victim_sel`

## Requirements
- R1: The victim appears on `vic_way` in the same cycle as the query, and `vic_valid` equals `q_valid`. An access that targets the queried set in that same cycle does not affect the answer; it is applied at the following clock edge.
- R2: After reset, way w of every set holds LRU age w, so the LRU victim is way NUM_WAYS-1. Every FIFO pointer is 0. The random generator holds the seed 16'hACE1.
- R3: In LRU state, any valid access (hit or fill) to way a of set s makes a the most recently used way of s. Ways that were more recent than a each move one step older. The other ways keep their relative order.
- R4: In LRU mode the victim is the least recently used way of the queried set.
- R5: In FIFO mode the victim is the set's pointer. A fill to the set advances the pointer by one, wrapping from NUM_WAYS-1 to 0, whatever way the fill names.
- R6: In FIFO state, a hit (`acc_fill` = 0) leaves the set's pointer unchanged.
- R7: In random mode the victim is the 16-bit generator value modulo NUM_WAYS, whatever the access history. On every clock after reset the generator v steps to {v[14:0], v[15]^v[13]^v[12]^v[10]}.
- R8: The `mode_sel` encoding is 0 = LRU, 1 = FIFO, 2 = random, and 3 = LRU. All policy state updates whatever the mode.
- R9: The victim is always below NUM_WAYS, including way counts that are not powers of two.
- R10: An access to one set leaves the state of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Policy selector (0 LRU, 1 FIFO, 2 random, 3 LRU) |
| acc_valid | input | 1 | Access notification present |
| acc_fill | input | 1 | 1 = fill, 0 = hit |
| acc_set | input | SET_W | Set of the access |
| acc_way | input | WAY_W | Way of the access, below NUM_WAYS |
| q_valid | input | 1 | Victim query present |
| q_set | input | SET_W | Set being queried |
| vic_valid | output | 1 | Victim answer present |
| vic_way | output | WAY_W | Chosen victim way |

## Verification
The bench builds one instance with 4 ways and 8 sets. This size gives the LRU reordering enough depth for a middle-of-list access to matter, and gives sets that can be touched in isolation. A second instance uses 3 ways and 2 sets. It covers a way count that is not a power of two, which brings the modulo reduction of the random value and the FIFO wrap at a non-binary boundary within reach. Both instances share reset timing, so the same generator sequence drives both.

// File: rtl/rpu_pkg.sv
package rpu_pkg;
  typedef enum logic [1:0] {
    POL_LRU   = 2'd0,
    POL_FIFO  = 2'd1,
    POL_RAND  = 2'd2,
    POL_LRU_B = 2'd3
  } policy_e;

  localparam logic [15:0] GEN_SEED = 16'hACE1;

  function automatic logic [15:0] gen_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction
endpackage

// File: rtl/rpu_lru_set.sv
module rpu_lru_set #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] age_q [NUM_WAYS];
  logic [WAY_W-1:0] ref_age;

  always_comb begin
    ref_age = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (touch_way == WAY_W'(w)) ref_age = age_q[w];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WAYS; w++) age_q[w] <= WAY_W'(w);
    end else if (touch) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (touch_way == WAY_W'(w)) age_q[w] <= '0;
        else if (age_q[w] < ref_age) age_q[w] <= age_q[w] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (age_q[w] == WAY_W'(NUM_WAYS - 1)) victim = WAY_W'(w);
  end
endmodule

// File: rtl/rpu_fifo_ptr.sv
module rpu_fifo_ptr #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill,
  output logic [WAY_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (fill) ptr <= (ptr == WAY_W'(NUM_WAYS - 1)) ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/rpu_lfsr.sv
module rpu_lfsr (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] state
);
  import rpu_pkg::*;
  always_ff @(posedge clk) begin
    if (!rst_n) state <= GEN_SEED;
    else        state <= gen_next(state);
  end
endmodule

// File: rtl/repl_victim_sel.sv
module repl_victim_sel #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 8,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             acc_valid,
  input  logic             acc_fill,
  input  logic [SET_W-1:0] acc_set,
  input  logic [WAY_W-1:0] acc_way,
  input  logic             q_valid,
  input  logic [SET_W-1:0] q_set,
  output logic             vic_valid,
  output logic [WAY_W-1:0] vic_way
);
  import rpu_pkg::*;

  logic [WAY_W-1:0] lru_vic  [NUM_SETS];
  logic [WAY_W-1:0] fifo_ptr [NUM_SETS];
  logic [15:0]      gen_q;
  logic [WAY_W-1:0] rand_way;
  logic [WAY_W-1:0] lru_pick, fifo_pick;
  policy_e          pol;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic hit_set;
    assign hit_set = acc_valid && (acc_set == SET_W'(s));

    rpu_lru_set #(.NUM_WAYS(NUM_WAYS)) u_lru (
      .clk(clk), .rst_n(rst_n), .touch(hit_set),
      .touch_way(acc_way), .victim(lru_vic[s]));

    rpu_fifo_ptr #(.NUM_WAYS(NUM_WAYS)) u_fifo (
      .clk(clk), .rst_n(rst_n), .fill(hit_set && acc_fill),
      .ptr(fifo_ptr[s]));
  end

  rpu_lfsr u_gen (.clk(clk), .rst_n(rst_n), .state(gen_q));

  assign rand_way = WAY_W'(gen_q % 16'(NUM_WAYS));

  always_comb begin
    lru_pick  = '0;
    fifo_pick = '0;
    for (int s = 0; s < NUM_SETS; s++) begin
      if (q_set == SET_W'(s)) begin
        lru_pick  = lru_vic[s];
        fifo_pick = fifo_ptr[s];
      end
    end
  end

  assign pol = policy_e'(mode_sel);

  always_comb begin
    unique case (pol)
      POL_FIFO: vic_way = fifo_pick;
      POL_RAND: vic_way = rand_way;
      default:  vic_way = lru_pick;
    endcase
  end

  assign vic_valid = q_valid;
endmodule

// File: rtl/repl_victim_sel_chk.sv
module repl_victim_sel_chk #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 8,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             acc_fill,
  input logic [SET_W-1:0] acc_set,
  input logic [WAY_W-1:0] acc_way,
  input logic             q_valid,
  input logic             vic_valid,
  input logic [WAY_W-1:0] vic_way,
  input logic [WAY_W-1:0] lru_vic  [NUM_SETS],
  input logic [WAY_W-1:0] fifo_ptr [NUM_SETS],
  input logic [15:0]      gen_q
);
  assert_victim_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> (int'(vic_way) < NUM_WAYS));

  assert_answer_same_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid == q_valid);

  // R3: the way just accessed can not be the least recent one
  assert_touched_not_victim_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> (lru_vic[$past(acc_set)] != $past(acc_way)));

  assert_hit_keeps_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_fill) |=> (fifo_ptr[$past(acc_set)] == $past(fifo_ptr[acc_set])));

  assert_fill_moves_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_fill) |=> (fifo_ptr[$past(acc_set)] != $past(fifo_ptr[acc_set])));

  assert_gen_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    gen_q != 16'h0);

  assert_gen_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> !$stable(gen_q));
endmodule

bind repl_victim_sel repl_victim_sel_chk #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_fill(acc_fill),
  .acc_set(acc_set), .acc_way(acc_way), .q_valid(q_valid),
  .vic_valid(vic_valid), .vic_way(vic_way), .lru_vic(lru_vic),
  .fifo_ptr(fifo_ptr), .gen_q(gen_q));

// File: tb/repl_victim_sel_tb.sv
module repl_victim_sel_tb;
  import rpu_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0] mode_sel = 2'd0;
  logic acc_valid = 1'b0, acc_fill = 1'b0, q_valid = 1'b0;
  logic [2:0] acc_set = '0, q_set = '0;
  logic [1:0] acc_way = '0;
  logic vic_valid;
  logic [1:0] vic_way;

  logic [1:0] m3_mode = 2'd0;
  logic m3_av = 1'b0, m3_af = 1'b0, m3_qv = 1'b0;
  logic m3_as = 1'b0, m3_qs = 1'b0;
  logic [1:0] m3_aw = '0;
  logic m3_vv;
  logic [1:0] m3_vw;

  repl_victim_sel #(.NUM_WAYS(4), .NUM_SETS(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .acc_valid(acc_valid),
    .acc_fill(acc_fill), .acc_set(acc_set), .acc_way(acc_way),
    .q_valid(q_valid), .q_set(q_set), .vic_valid(vic_valid), .vic_way(vic_way));

  repl_victim_sel #(.NUM_WAYS(3), .NUM_SETS(2)) u_dut3 (
    .clk(clk), .rst_n(rst_n), .mode_sel(m3_mode), .acc_valid(m3_av),
    .acc_fill(m3_af), .acc_set(m3_as), .acc_way(m3_aw),
    .q_valid(m3_qv), .q_set(m3_qs), .vic_valid(m3_vv), .vic_way(m3_vw));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state: order[s][0] is most recent
  int order [8][4];
  int fptr  [8];
  logic [15:0] mgen;

  always @(posedge clk) begin
    if (!rst_n) mgen <= 16'hACE1;
    else        mgen <= {mgen[14:0], mgen[15] ^ mgen[13] ^ mgen[12] ^ mgen[10]};
  end

  task automatic model_reset();
    for (int s = 0; s < 8; s++) begin
      for (int k = 0; k < 4; k++) order[s][k] = k;
      fptr[s] = 0;
    end
  endtask

  task automatic model_access(input int s, input int w, input bit fill);
    int p = 0;
    for (int k = 0; k < 4; k++) if (order[s][k] == w) p = k;
    for (int k = p; k > 0; k--) order[s][k] = order[s][k-1];
    order[s][0] = w;
    if (fill) fptr[s] = (fptr[s] + 1) % 4;
  endtask

  function automatic int expect_vic(input int m, input int s);
    if (m == 1) return fptr[s];
    if (m == 2) return int'(mgen % 16'd4);
    return order[s][3];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle on the main instance: drive, sample the pre-update answer, apply edge
  task automatic step(input int m, input bit av, input bit af, input int s,
                      input int w, input int qs, input string req);
    int e;
    @(negedge clk);
    mode_sel = 2'(m); acc_valid = av; acc_fill = af;
    acc_set = 3'(s); acc_way = 2'(w); q_valid = 1'b1; q_set = 3'(qs);
    #1;
    e = expect_vic(m, qs);
    chk(vic_valid && int'(vic_way) == e, req, int'(vic_way), e);
    @(posedge clk);
    #1;
    if (av) model_access(s, w, af);
    acc_valid = 1'b0;
  endtask

  // fields: mode[11:10] av[9] af[8] set[7:5] way[4:3] qset[2:0]
  localparam logic [11:0] VECS [16] = '{
    {2'd0, 1'b1, 1'b0, 3'd2, 2'd3, 3'd2},
    {2'd0, 1'b1, 1'b0, 3'd2, 2'd0, 3'd2},
    {2'd0, 1'b1, 1'b1, 3'd2, 2'd2, 3'd2},
    {2'd0, 1'b0, 1'b0, 3'd2, 2'd0, 3'd2},
    {2'd1, 1'b1, 1'b1, 3'd2, 2'd0, 3'd2},
    {2'd1, 1'b1, 1'b0, 3'd2, 2'd1, 3'd2},
    {2'd1, 1'b0, 1'b0, 3'd2, 2'd0, 3'd2},
    {2'd1, 1'b1, 1'b1, 3'd2, 2'd2, 3'd2},
    {2'd1, 1'b0, 1'b0, 3'd2, 2'd0, 3'd2},
    {2'd2, 1'b1, 1'b0, 3'd4, 2'd1, 3'd4},
    {2'd2, 1'b0, 1'b0, 3'd4, 2'd0, 3'd4},
    {2'd0, 1'b0, 1'b0, 3'd4, 2'd0, 3'd4},
    {2'd3, 1'b1, 1'b0, 3'd4, 2'd3, 3'd4},
    {2'd0, 1'b0, 1'b0, 3'd4, 2'd0, 3'd4},
    {2'd1, 1'b0, 1'b0, 3'd4, 2'd0, 3'd4},
    {2'd0, 1'b0, 1'b0, 3'd2, 2'd0, 3'd2}
  };

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: reset state of every set in each policy
    for (int s = 0; s < 8; s++) begin
      step(0, 0, 0, 0, 0, s, "R2 lru reset");
      step(1, 0, 0, 0, 0, s, "R2 fifo reset");
    end
    step(2, 0, 0, 0, 0, 0, "R2 seed");

    // vector walk: R1 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 16; i++) begin
      logic [11:0] v = VECS[i];
      string req;
      case (v[11:10])
        2'd1:    req = "R5/R6 fifo";
        2'd2:    req = "R7 random";
        2'd3:    req = "R8 mode3 as lru";
        default: req = "R3/R4 lru";
      endcase
      step(int'(v[11:10]), v[9], v[8], int'(v[7:5]), int'(v[4:3]), int'(v[2:0]), req);
    end

    // R1: same-cycle access and query on one set sees the old victim
    step(0, 1, 0, 6, 3, 6, "R1 pre-update answer");
    step(0, 0, 0, 6, 0, 6, "R1 update visible next cycle");

    // R6: a burst of hits leaves the FIFO pointer of set 7 alone
    step(1, 1, 1, 7, 0, 7, "R5 fill");
    for (int k = 0; k < 4; k++) step(1, 1, 0, 7, k, 7, "R6 hit ignored");
    step(1, 0, 0, 7, 0, 7, "R6 ptr after hits");

    // R5: wrap of the pointer on set 0
    for (int k = 0; k < 5; k++) step(1, 1, 1, 0, 1, 0, "R5 wrap");

    // R10: heavy traffic on set 3 leaves set 5 at reset values
    for (int k = 0; k < 4; k++) step(0, 1, 1, 3, k, 3, "R10 traffic");
    step(0, 0, 0, 0, 0, 5, "R10 lru other set");
    step(1, 0, 0, 0, 0, 5, "R10 fifo other set");

    // R7: random answer follows generator with no accesses
    for (int k = 0; k < 6; k++) step(2, 0, 0, 0, 0, 1, "R7 free run");

    // 3-way instance: R9 R2 R5 R7
    @(negedge clk);
    m3_qv = 1'b1; m3_qs = 1'b0; m3_mode = 2'd0;
    #1;
    chk(m3_vv && m3_vw == 2'd2, "R2 3-way lru reset", int'(m3_vw), 2);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      m3_mode = 2'd1; m3_qs = 1'b1; m3_av = 1'b1; m3_af = 1'b1; m3_as = 1'b1; m3_aw = 2'd0;
      #1;
      chk(int'(m3_vw) == (k % 3), "R5 3-way wrap", int'(m3_vw), k % 3);
      @(posedge clk);
      #1;
      m3_av = 1'b0;
    end
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      m3_mode = 2'd2;
      #1;
      chk(int'(m3_vw) == int'(mgen % 16'd3) && m3_vw < 2'd3, "R9 3-way random",
          int'(m3_vw), int'(mgen % 16'd3));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule